// File: doc/BRIEF.md
# IDE Channel Interrupt Latch and Router

This block sits between two disk-interface channels and the system interrupt fabric. Each channel presents a status byte with a strobe. Bit 2 of that byte is the channel's interrupt request. The block keeps two records of each request.

The first record is a sticky flag that software reads back. Once the flag is set, it stays set until software reads the register that holds it. Channel 0's flag sits in bit 2 of the register at address 0x50. Channel 1's flag sits in bit 4 of the register at address 0x57. Reading either register returns the flag and clears it in the same access.

The second record is the live request level. This level is routed to an output line that depends on a per-channel routing mode. In legacy mode, channel 0 drives the IRQ 14 line and channel 1 drives the IRQ 15 line. In native mode, the request drives one shared level-sensitive PCI interrupt pin, and both channels can drive that pin at once.

The routing modes are loaded from a programming-interface byte. Channel 0 takes bit 0 of that byte and channel 1 takes bit 2. A channel marked absent still records its flag, but it drives no interrupt line.

Top module: `irq_latch_router`

## Requirements
- R1: A strobe whose status byte has bit 2 set sets that channel's flag, and the flag output shows it after the same clock edge.
- R2: A set flag is not cleared by a later strobe whose bit 2 is clear; only a read of its register clears it.
- R3: A strobe with bit 2 clear leaves a clear flag clear, whatever the other status bits hold.
- R4: A read of address 0x50 returns channel 0's flag in bit 2, and a read of 0x57 returns channel 1's flag in bit 4, on rd_data one cycle after rd_stb. All other bits are 0. The read clears that flag. A read of any other address returns 0 and clears nothing. rd_data is 0 in any cycle without a read.
- R5: When a setting strobe and a read of the same flag fall in one cycle, the read returns the value before the edge and the flag ends set.
- R6: In legacy mode (0), irq14 follows channel 0's request level and irq15 follows channel 1's. The level is taken from bit 2 of the channel's latest strobe.
- R7: In native mode (1), a channel's request drives pci_inta. pci_inta is the OR of every present native-mode channel's request, so one channel dropping does not drop a request still pending from the other.
- R8: A write to the programming-interface byte loads channel 0's mode from bit 0 and channel 1's mode from bit 2. Reset returns both modes to legacy.
- R9: While a channel's enable is low, its flag still updates, but its request level is not updated and it drives no interrupt output.
- R10: During and right after reset, all flags, interrupt lines and rd_data are 0.
- R11: All outputs are registered. A strobe, enable change or mode write sampled at a clock edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch0_stat | input | 8 | Channel 0 status byte (bit 2 = request) |
| ch0_stb | input | 1 | Channel 0 status strobe |
| ch1_stat | input | 8 | Channel 1 status byte (bit 2 = request) |
| ch1_stb | input | 1 | Channel 1 status strobe |
| pif_wr | input | 1 | Load routing modes from pif_val |
| pif_val | input | 8 | Programming-interface byte (bit 0 = ch0 mode, bit 2 = ch1 mode) |
| chan_en | input | 2 | Channel present enables, bit n for channel n |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after rd_stb |
| irq14 | output | 1 | Legacy interrupt line for channel 0 |
| irq15 | output | 1 | Legacy interrupt line for channel 1 |
| pci_inta | output | 1 | Shared native-mode interrupt pin |
| flag0 | output | 1 | Channel 0 sticky flag |
| flag1 | output | 1 | Channel 1 sticky flag |

## Verification
The bench first targets the cycle where a setting strobe and a clearing read meet. A design that lets the clear win would lose an interrupt. A design that returns the new value would report a request that software never saw.

It also drops one native-mode channel while the other still requests. A design that forwards only the last writer would then release the shared pin too early.

Absent channels and strobes with only non-request bits set are mixed in. These expose a flag that ignores disabled channels, a line that fires while its channel is absent, and a flag copied from the whole status byte.

A mode write followed by a reset checks that routing returns to the legacy lines.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt latch/router: channel count, status
// widths and the per-channel register placement that software decodes.
package irq_route_pkg;
    localparam int NCH     = 2;
    localparam int STAT_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int REQ_BIT = 2;

    // Register address holding each channel's sticky flag.
    localparam logic [ADDR_W-1:0] FLAG_ADDR [NCH] = '{8'h50, 8'h57};
    // Bit position of the flag inside that register.
    localparam int FLAG_POS [NCH] = '{2, 4};
    // Bit of the programming-interface byte that selects native routing.
    localparam int MODE_POS [NCH] = '{0, 2};
endpackage

// File: rtl/irq_flag_cell.sv
`timescale 1ns/1ps
// One channel's request state: a sticky flag that is set by a request and
// cleared by a read, plus the live request level used for routing.
// Assumes: a set and a clear in the same cycle resolve in favour of the set.
module irq_flag_cell #(
    parameter int STAT_W  = 8,
    parameter int REQ_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat,
    input  logic              stb,
    input  logic              present,
    input  logic              clr,
    output logic              flag_q,
    output logic              req_d
);
    logic req_q;
    logic req_hit;

    assign req_hit = stb && stat[REQ_BIT];

    // Sticky flag: a request sets it, a read clears it, and the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (req_hit) flag_q <= 1'b1;
        else if (clr)     flag_q <= 1'b0;
    end

    // Next request level: follows each strobe, but only while present.
    always_comb begin
        req_d = req_q;
        if (stb && present) req_d = stat[REQ_BIT];
    end

    // Request level register.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end
endmodule

// File: rtl/irq_route_mux.sv
`timescale 1ns/1ps
// Holds the per-channel routing mode and drives the registered interrupt
// outputs: one legacy line per channel, plus a shared native pin that is
// the OR of every native-mode request.
// Assumes: req_d holds the next-cycle request levels.
module irq_route_mux #(
    parameter int NCH    = 2,
    parameter int PIF_W  = 8,
    parameter int MODE_POS [NCH] = '{0, 2}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_d,
    input  logic [NCH-1:0]   en,
    input  logic             pif_wr,
    input  logic [PIF_W-1:0] pif_val,
    output logic [NCH-1:0]   leg_q,
    output logic             pci_q
);
    logic [NCH-1:0] mode_q;
    logic [NCH-1:0] mode_d;
    logic [NCH-1:0] live;
    logic           pci_d;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Next routing mode for this channel.
        assign mode_d[c] = pif_wr ? pif_val[MODE_POS[c]] : mode_q[c];
        assign live[c]   = req_d[c] && en[c];

        // Mode register, legacy after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) mode_q[c] <= 1'b0;
            else        mode_q[c] <= mode_d[c];
        end

        // Legacy line register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) leg_q[c] <= 1'b0;
            else        leg_q[c] <= live[c] && !mode_d[c];
        end
    end

    // OR of the native-mode requests onto the shared pin.
    always_comb begin
        pci_d = 1'b0;
        for (int c = 0; c < NCH; c++) pci_d = pci_d | (live[c] && mode_d[c]);
    end

    // Shared pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) pci_q <= 1'b0;
        else        pci_q <= pci_d;
    end
endmodule

// File: rtl/irq_status_read.sv
`timescale 1ns/1ps
// Read port for the sticky flags: decodes the address, returns the flag in
// its bit position one cycle later and issues the per-channel clear.
// Assumes: the channels' flag addresses are distinct.
module irq_status_read #(
    parameter int NCH    = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR [NCH] = '{8'h50, 8'h57},
    parameter int FLAG_POS [NCH] = '{2, 4}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NCH-1:0]    flag_q,
    output logic [NCH-1:0]    clr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] data_d;

    for (genvar c = 0; c < NCH; c++) begin : g_dec
        assign clr[c] = rd_stb && (rd_addr == FLAG_ADDR[c]);
    end

    // Assemble the read value from the flags before this edge.
    always_comb begin
        data_d = '0;
        for (int c = 0; c < NCH; c++)
            if (clr[c]) data_d[FLAG_POS[c]] = flag_q[c];
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= data_d;
    end
endmodule

// File: rtl/irq_latch_router.sv
`timescale 1ns/1ps
// Top of the interrupt latch/router: two channel cells, a read port that
// clears flags, and a router that steers request levels by mode.
// Assumes: synchronous active-low reset; all outputs are registered.
module irq_latch_router
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] ch0_stat,
    input  logic              ch0_stb,
    input  logic [STAT_W-1:0] ch1_stat,
    input  logic              ch1_stb,
    input  logic              pif_wr,
    input  logic [7:0]        pif_val,
    input  logic [NCH-1:0]    chan_en,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq14,
    output logic              irq15,
    output logic              pci_inta,
    output logic              flag0,
    output logic              flag1
);
    logic [STAT_W-1:0] stat [NCH];
    logic [NCH-1:0]    stb;
    logic [NCH-1:0]    clr;
    logic [NCH-1:0]    flag_q;
    logic [NCH-1:0]    req_d;
    logic [NCH-1:0]    leg_q;

    assign stat[0] = ch0_stat;
    assign stat[1] = ch1_stat;
    assign stb     = {ch1_stb, ch0_stb};

    for (genvar c = 0; c < NCH; c++) begin : g_cell
        irq_flag_cell #(.STAT_W(STAT_W), .REQ_BIT(REQ_BIT)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .stat    (stat[c]),
            .stb     (stb[c]),
            .present (chan_en[c]),
            .clr     (clr[c]),
            .flag_q  (flag_q[c]),
            .req_d   (req_d[c])
        );
    end

    irq_status_read #(
        .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FLAG_ADDR(FLAG_ADDR), .FLAG_POS(FLAG_POS)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .flag_q  (flag_q),
        .clr     (clr),
        .rd_data (rd_data)
    );

    irq_route_mux #(.NCH(NCH), .PIF_W(8), .MODE_POS(MODE_POS)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_d   (req_d),
        .en      (chan_en),
        .pif_wr  (pif_wr),
        .pif_val (pif_val),
        .leg_q   (leg_q),
        .pci_q   (pci_inta)
    );

    assign irq14 = leg_q[0];
    assign irq15 = leg_q[1];
    assign flag0 = flag_q[0];
    assign flag1 = flag_q[1];
endmodule

// File: rtl/irq_latch_router_chk.sv
`timescale 1ns/1ps
// Port-level checker for irq_latch_router, attached by bind.
module irq_latch_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ch0_stat,
    input logic       ch0_stb,
    input logic [7:0] ch1_stat,
    input logic       ch1_stb,
    input logic [1:0] chan_en,
    input logic       rd_stb,
    input logic [7:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       irq14,
    input logic       irq15,
    input logic       pci_inta,
    input logic       flag0,
    input logic       flag1
);
    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_stb && ch0_stat[2]) |=> flag0);

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag1 && !(rd_stb && rd_addr == 8'h57)) |=> flag1);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == 8'h50 && !(ch0_stb && ch0_stat[2])) |=> !flag0);

    assert_idle_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> (rd_data == 8'h00));

    assert_collide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == 8'h57 && ch1_stb && ch1_stat[2]) |=> flag1);

    assert_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en == 2'b00) |=> (!irq14 && !irq15 && !pci_inta));
endmodule

bind irq_latch_router irq_latch_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ch0_stat(ch0_stat), .ch0_stb(ch0_stb),
    .ch1_stat(ch1_stat), .ch1_stb(ch1_stb), .chan_en(chan_en),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq14(irq14), .irq15(irq15), .pci_inta(pci_inta),
    .flag0(flag0), .flag1(flag1)
);

// File: tb/sim_irq_latch_router.sv
`timescale 1ns/1ps
module sim_irq_latch_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ch0_stat = 8'h00, ch1_stat = 8'h00, pif_val = 8'h00, rd_addr = 8'h00;
    logic       ch0_stb = 1'b0, ch1_stb = 1'b0, pif_wr = 1'b0, rd_stb = 1'b0;
    logic [1:0] chan_en = 2'b11;
    logic [7:0] rd_data;
    logic       irq14, irq15, pci_inta, flag0, flag1;

    int total = 0;
    int bad = 0;

    // Reference state
    logic [1:0] m_flag = 2'b00, m_req = 2'b00, m_mode = 2'b00;
    logic       e14, e15, epci;
    logic [7:0] erd;

    always #2.5 clk = ~clk;

    irq_latch_router u0 (
        .clk(clk), .rst_n(rst_n), .ch0_stat(ch0_stat), .ch0_stb(ch0_stb),
        .ch1_stat(ch1_stat), .ch1_stb(ch1_stb), .pif_wr(pif_wr), .pif_val(pif_val),
        .chan_en(chan_en), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq14(irq14), .irq15(irq15), .pci_inta(pci_inta), .flag0(flag0), .flag1(flag1)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] addr_of(input int c);
        return (c == 0) ? 8'h50 : 8'h57;
    endfunction

    // Advance the reference by one edge using the current inputs.
    task automatic model_step();
        logic [7:0] st;
        logic       sb, hit, clr;
        logic [1:0] f_n, r_n, md_n;
        erd = 8'h00;
        md_n = pif_wr ? {pif_val[2], pif_val[0]} : m_mode;
        for (int c = 0; c < 2; c++) begin
            st  = (c == 0) ? ch0_stat : ch1_stat;
            sb  = (c == 0) ? ch0_stb : ch1_stb;
            hit = sb && st[2];
            clr = rd_stb && rd_addr == addr_of(c);
            if (clr) erd[(c == 0) ? 2 : 4] = m_flag[c];
            f_n[c] = hit ? 1'b1 : (clr ? 1'b0 : m_flag[c]);
            r_n[c] = (sb && chan_en[c]) ? st[2] : m_req[c];
        end
        m_flag = f_n; m_req = r_n; m_mode = md_n;
        e14  = m_req[0] && chan_en[0] && !m_mode[0];
        e15  = m_req[1] && chan_en[1] && !m_mode[1];
        epci = (m_req[0] && chan_en[0] && m_mode[0]) || (m_req[1] && chan_en[1] && m_mode[1]);
    endtask

    // One clock with full output comparison, then strobes drop.
    task automatic step();
        model_step();
        @(posedge clk); #1;
        chk("R1 flag0", {7'b0, flag0}, {7'b0, m_flag[0]});
        chk("R1 flag1", {7'b0, flag1}, {7'b0, m_flag[1]});
        chk("R4 rd_data", rd_data, erd);
        chk("R6 irq14", {7'b0, irq14}, {7'b0, e14});
        chk("R6 irq15", {7'b0, irq15}, {7'b0, e15});
        chk("R7 pci_inta", {7'b0, pci_inta}, {7'b0, epci});
        ch0_stb = 1'b0; ch1_stb = 1'b0; pif_wr = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ch0_stb = 1'b0; ch1_stb = 1'b0; pif_wr = 1'b0; rd_stb = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_flag = 2'b00; m_req = 2'b00; m_mode = 2'b00;
        chk("R10 reset outputs", {rd_data}, 8'h00);
        chk("R10 reset lines", {3'b0, irq14, irq15, pci_inta, flag0, flag1}, 8'h00);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // R1/R11: request sets flag and legacy line on the same edge
        ch0_stat = 8'h04; ch0_stb = 1'b1; step();
        chk("R11 irq14 after edge", {7'b0, irq14}, 8'h01);
        // R2: non-request strobe keeps flag, drops level
        ch0_stat = 8'h00; ch0_stb = 1'b1; step();
        chk("R2 flag0 sticky", {7'b0, flag0}, 8'h01);
        chk("R6 irq14 dropped", {7'b0, irq14}, 8'h00);
        // R4: read returns then clears
        rd_stb = 1'b1; rd_addr = 8'h50; step();
        chk("R4 read 0x50 data", rd_data, 8'h04);
        chk("R4 flag0 cleared", {7'b0, flag0}, 8'h00);
        // R4: unrelated address
        rd_stb = 1'b1; rd_addr = 8'h51; step();
        chk("R4 other addr", rd_data, 8'h00);
        // R3: other status bits do not set the flag
        ch0_stat = 8'hFB; ch0_stb = 1'b1; step();
        chk("R3 flag0 stays clear", {7'b0, flag0}, 8'h00);
        // R5: collision with clear flag, then with set flag
        ch1_stat = 8'h04; ch1_stb = 1'b1; rd_stb = 1'b1; rd_addr = 8'h57; step();
        chk("R5 old value returned", rd_data, 8'h00);
        chk("R5 set wins", {7'b0, flag1}, 8'h01);
        ch1_stat = 8'h04; ch1_stb = 1'b1; rd_stb = 1'b1; rd_addr = 8'h57; step();
        chk("R5 set value returned", rd_data, 8'h10);
        chk("R5 flag1 remains", {7'b0, flag1}, 8'h01);
        // R8/R7: native routing for both channels, shared pin OR
        pif_wr = 1'b1; pif_val = 8'h05; step();
        chk("R8 irq15 moved off legacy", {7'b0, irq15}, 8'h00);
        chk("R8 pci from ch1", {7'b0, pci_inta}, 8'h01);
        ch0_stat = 8'h04; ch0_stb = 1'b1; step();
        ch1_stat = 8'h00; ch1_stb = 1'b1; step();
        chk("R7 pci held by ch0", {7'b0, pci_inta}, 8'h01);
        ch0_stat = 8'h00; ch0_stb = 1'b1; step();
        chk("R7 pci released", {7'b0, pci_inta}, 8'h00);
        // R9: absent channel still flags, drives nothing
        pif_wr = 1'b1; pif_val = 8'h00; chan_en = 2'b10;
        rd_stb = 1'b1; rd_addr = 8'h50; step();
        ch0_stat = 8'h04; ch0_stb = 1'b1; step();
        chk("R9 flag0 set while absent", {7'b0, flag0}, 8'h01);
        chk("R9 no irq14 while absent", {7'b0, irq14}, 8'h00);
        chan_en = 2'b11; step();
        chk("R9 level not taken while absent", {7'b0, irq14}, 8'h00);

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            ch0_stat = 8'($urandom); ch1_stat = 8'($urandom);
            ch0_stb = r[0]; ch1_stb = r[1];
            rd_stb = r[2] & r[3];
            rd_addr = r[4] ? (r[5] ? 8'h50 : 8'h57) : 8'($urandom);
            pif_wr = (r[9:6] == 4'd0);
            pif_val = 8'($urandom);
            if (r[13:10] == 4'd0) chan_en = 2'($urandom);
            step();
        end

        // R8: reset returns routing to legacy
        pif_wr = 1'b1; pif_val = 8'h05; chan_en = 2'b11; step();
        do_reset();
        ch0_stat = 8'h04; ch0_stb = 1'b1; step();
        chk("R8 legacy after reset irq14", {7'b0, irq14}, 8'h01);
        chk("R8 legacy after reset pci", {7'b0, pci_inta}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule